// File: doc/BRIEF.md
# Bit-Slip Serial Frame Aligner

This block finds character boundaries in a continuous asynchronous bit stream that has no idle gaps between characters. It sits behind a bit sampler that already delivers one recovered bit per bit period, marked by a valid strobe. It keeps the last ten bits in a sliding window. It treats that window as a possible character: a low start bit, eight data bits taken least-significant first, and a high stop bit.

While searching, the aligner tests the window at every bit position. If the test fails, that alignment is dropped and the window moves on by a single bit. Passing the character test can happen by chance, so it is never taken as lock on its own. Lock is declared only after two character-aligned frames carry the two fixed header values one after the other. Once locked, only every tenth bit position is tested. The aligner then delivers a parameterised number of payload bytes, each with a strobe. It checks a trailing XOR check byte and reports each packet as good or bad with a one-cycle pulse.

Top module: `serial_frame_aligner`

## Requirements
- R1: While reset is high and in the first cycle after it, `locked`, `byte_valid`, `pkt_good` and `pkt_bad` are all low.
- R2: A character is ten bits in arrival order: start bit 0, eight data bits least-significant first, stop bit 1. Each payload character of a packet is emitted on `byte_data` with a one-cycle `byte_valid` in the cycle after its stop bit is accepted. There are exactly PAY_LEN payload bytes per packet, and `byte_valid` is only ever high while `locked` is high.
- R3: While hunting, the window is tested at every accepted bit. A failing position advances the test by one bit. A packet is therefore found whatever the bit offset at which the stream begins.
- R4: A packet header is a character carrying SYNC_A followed at once by a character carrying SYNC_B. A SYNC_A character followed by any other value does not lock, and hunting resumes at the next bit.
- R5: `locked` rises in the cycle after the stop bit of the SYNC_B header character is accepted, and never without an accepted bit in the cycle before.
- R6: While locked, characters are tested only every tenth accepted bit. Consecutive `byte_valid` pulses within one packet are exactly ten accepted bits apart.
- R7: A character test failure on a payload or check character while locked gives one `pkt_bad` pulse, drops `locked`, and resumes bit-by-bit hunting.
- R8: A check character equal to the XOR of the packet's payload bytes gives one `pkt_good` pulse, and lock is held to receive the next header.
- R9: A check character that differs from that XOR gives one `pkt_bad` pulse, and lock is held.
- R10: While locked, a header character that does not match, or fails the character test, drops `locked` with no packet pulse.
- R11: In a cycle with `bit_valid` low, nothing advances: no output pulse follows and `locked` keeps its value.
- R12: `pkt_good` and `pkt_bad` are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A recovered bit is present on bit_in this cycle |
| bit_in | input | 1 | Recovered serial bit |
| byte_valid | output | 1 | One-cycle strobe for a payload byte |
| byte_data | output | 8 | Payload byte value |
| pkt_good | output | 1 | One-cycle pulse: packet check byte matched |
| pkt_bad | output | 1 | One-cycle pulse: packet check byte wrong or character broken |
| locked | output | 1 | Character alignment confirmed by the header |

## Verification
The assertions check several rules on every cycle. Payload strobes and good-packet pulses occur only under lock. Idle cycles change nothing. The two packet pulses are exclusive single-cycle events. Lock rises only on an accepted bit. Payload strobes within a packet are exactly ten accepted bits apart. Other behaviour needs the bench's directed scenarios. These are recovery from every starting bit offset and from a stream joined mid-packet. They also cover rejection of a lone first header byte, delivered byte values, and the response to a wrong check byte, a broken stop bit and a bad header while locked.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int FRAME_W = 10;

    // window layout: oldest bit at position 0
    typedef struct packed {
        logic       stop;
        logic [7:0] data;
        logic       start;
    } frame_t;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYNC2,
        ST_HDR1,
        ST_HDR2,
        ST_PAY,
        ST_CHK
    } state_e;

    function automatic logic frame_ok(frame_t f);
        return (f.start == 1'b0) && (f.stop == 1'b1);
    endfunction

    function automatic logic state_locked(state_e s);
        return (s == ST_HDR1) || (s == ST_HDR2) || (s == ST_PAY) || (s == ST_CHK);
    endfunction

endpackage

// File: rtl/sfa_window.sv
module sfa_window
    import sfa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_valid,
    input  logic   bit_in,
    output frame_t cand,
    output logic   full
);
    localparam int FW = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] win;
    logic [FW-1:0]      fill;

    // candidate frame as it will look once this bit is shifted in
    assign cand = frame_t'({bit_in, win[FRAME_W-1:1]});
    assign full = (fill >= FW'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            win  <= '1;
            fill <= '0;
        end else if (bit_valid) begin
            win <= {bit_in, win[FRAME_W-1:1]};
            if (fill != FW'(FRAME_W))
                fill <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/sfa_csum.sv
module sfa_csum (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (en)
            acc <= acc ^ din;
    end
endmodule

// File: rtl/sfa_ctrl.sv
module sfa_ctrl
    import sfa_pkg::*;
#(
    parameter int         PAY_LEN = 4,
    parameter logic [7:0] SYNC_A  = 8'hD3,
    parameter logic [7:0] SYNC_B  = 8'h2C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_valid,
    input  frame_t     cand,
    input  logic       full,
    input  logic [7:0] acc,
    output logic       csum_clr,
    output logic       csum_en,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       pkt_good,
    output logic       pkt_bad,
    output logic       locked
);
    localparam int         CW      = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1;
    localparam logic [3:0] PH_LAST = 4'(FRAME_W - 1);

    state_e        state;
    logic [3:0]    ph;
    logic [CW-1:0] pcnt;
    logic          ok;
    logic          at_check;
    logic          hdr_done;

    assign ok       = frame_ok(cand);
    assign at_check = bit_valid && (state != ST_HUNT) && (ph == PH_LAST);
    assign hdr_done = at_check && ((state == ST_SYNC2) || (state == ST_HDR2))
                      && ok && (cand.data == SYNC_B);
    assign csum_clr = hdr_done;
    assign csum_en  = at_check && (state == ST_PAY) && ok;
    assign locked   = state_locked(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HUNT;
            ph         <= '0;
            pcnt       <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            pkt_good   <= 1'b0;
            pkt_bad    <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            pkt_good   <= 1'b0;
            pkt_bad    <= 1'b0;
            if (bit_valid) begin
                if (state == ST_HUNT) begin
                    if (full && ok && (cand.data == SYNC_A)) begin
                        state <= ST_SYNC2;
                        ph    <= '0;
                    end
                end else if (ph != PH_LAST) begin
                    ph <= ph + 1'b1;
                end else begin
                    ph <= '0;
                    unique case (state)
                        ST_SYNC2, ST_HDR2: begin
                            pcnt  <= '0;
                            state <= hdr_done ? ST_PAY : ST_HUNT;
                        end
                        ST_HDR1: begin
                            state <= (ok && (cand.data == SYNC_A)) ? ST_HDR2 : ST_HUNT;
                        end
                        ST_PAY: begin
                            if (!ok) begin
                                pkt_bad <= 1'b1;
                                state   <= ST_HUNT;
                            end else begin
                                byte_valid <= 1'b1;
                                byte_data  <= cand.data;
                                if (pcnt == CW'(PAY_LEN - 1))
                                    state <= ST_CHK;
                                else
                                    pcnt <= pcnt + 1'b1;
                            end
                        end
                        ST_CHK: begin
                            if (!ok) begin
                                pkt_bad <= 1'b1;
                                state   <= ST_HUNT;
                            end else begin
                                pkt_good <= (cand.data == acc);
                                pkt_bad  <= (cand.data != acc);
                                state    <= ST_HDR1;
                            end
                        end
                        default: state <= ST_HUNT;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/serial_frame_aligner.sv
module serial_frame_aligner
    import sfa_pkg::*;
#(
    parameter int         PAY_LEN = 4,
    parameter logic [7:0] SYNC_A  = 8'hD3,
    parameter logic [7:0] SYNC_B  = 8'h2C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_valid,
    input  logic       bit_in,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       pkt_good,
    output logic       pkt_bad,
    output logic       locked
);
    frame_t     cand;
    logic       full;
    logic       csum_clr;
    logic       csum_en;
    logic [7:0] acc;

    sfa_window u_win (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .cand      (cand),
        .full      (full)
    );

    sfa_csum u_csum (
        .clk (clk),
        .rst (rst),
        .clr (csum_clr),
        .en  (csum_en),
        .din (cand.data),
        .acc (acc)
    );

    sfa_ctrl #(
        .PAY_LEN (PAY_LEN),
        .SYNC_A  (SYNC_A),
        .SYNC_B  (SYNC_B)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .cand       (cand),
        .full       (full),
        .acc        (acc),
        .csum_clr   (csum_clr),
        .csum_en    (csum_en),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .pkt_good   (pkt_good),
        .pkt_bad    (pkt_bad),
        .locked     (locked)
    );
endmodule

// File: rtl/sfa_checker.sv
module sfa_checker (
    input logic clk,
    input logic rst,
    input logic bit_valid,
    input logic byte_valid,
    input logic pkt_good,
    input logic pkt_bad,
    input logic locked
);
    logic [5:0] gap_cnt;
    logic       armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= '0;
            armed   <= 1'b0;
        end else begin
            if (byte_valid) begin
                gap_cnt <= {5'd0, bit_valid};
                armed   <= 1'b1;
            end else if (bit_valid && gap_cnt != 6'h3F) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (!locked || pkt_good || pkt_bad)
                armed <= 1'b0;
        end
    end

    // R12
    pkt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pkt_good, pkt_bad}));

    // R12
    pkt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_good || pkt_bad) |=> !(pkt_good || pkt_bad));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> (!byte_valid && !pkt_good && !pkt_bad && $stable(locked)));

    // R2
    byte_lock_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> locked);

    // R8
    good_lock_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_good |-> locked);

    // R5
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(bit_valid));

    // R6
    byte_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && armed) |-> (gap_cnt == 6'd10));
endmodule

bind serial_frame_aligner sfa_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .byte_valid (byte_valid),
    .pkt_good   (pkt_good),
    .pkt_bad    (pkt_bad),
    .locked     (locked)
);

// File: tb/serial_frame_aligner_test.sv
`timescale 1ns/100ps
module serial_frame_aligner_test;
    localparam int         PAY_LEN = 4;
    localparam logic [7:0] SA      = 8'hD3;
    localparam logic [7:0] SB      = 8'h2C;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b1;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       pkt_good;
    logic       pkt_bad;
    logic       locked;

    int         checks = 0;
    int         errors = 0;
    int         rx_n = 0;
    int         good_n = 0;
    int         bad_n = 0;
    logic [7:0] rx_q [0:63];
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    serial_frame_aligner #(
        .PAY_LEN (PAY_LEN),
        .SYNC_A  (SA),
        .SYNC_B  (SB)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .bit_in     (bit_in),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .pkt_good   (pkt_good),
        .pkt_bad    (pkt_bad),
        .locked     (locked)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (rx_n < 64) rx_q[rx_n] = byte_data;
                rx_n++;
            end
            if (pkt_good) good_n++;
            if (pkt_bad)  bad_n++;
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        bit_valid = 1'b0;
        bit_in    = 1'b1;
        repeat (3) @(negedge clk);
        rst    = 1'b0;
        rx_n   = 0;
        good_n = 0;
        bad_n  = 0;
    endtask

    task automatic flush();
        bit_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int gap);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stop, input int gap);
        send_bit(1'b0, gap);
        for (int j = 0; j < 8; j++) send_bit(d[j], gap);
        send_bit(stop, gap);
    endtask

    // header, four payload bytes, check byte; bad_stop picks a frame with a broken stop bit
    task automatic send_pkt(input logic [7:0] h1, input logic [7:0] h2,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3,
                            input logic [7:0] ck, input int bad_stop,
                            input int skip, input int gap);
        logic [7:0] f [0:6];
        logic       b;
        f[0] = h1; f[1] = h2; f[2] = b0; f[3] = b1; f[4] = b2; f[5] = b3; f[6] = ck;
        for (int fi = 0; fi < 7; fi++) begin
            for (int j = 0; j < 10; j++) begin
                if (j == 0)      b = 1'b0;
                else if (j == 9) b = (fi == bad_stop) ? 1'b0 : 1'b1;
                else             b = f[fi][j-1];
                if (fi * 10 + j >= skip) send_bit(b, gap);
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        // R1
        chk(!locked, "R1 locked after reset", locked, 0);
        chk(!byte_valid && !pkt_good && !pkt_bad, "R1 pulses after reset",
            {byte_valid, pkt_good, pkt_bad}, 0);
    endtask

    task automatic t_basic();
        logic [7:0] p [0:3];
        p[0] = 8'h11; p[1] = 8'h22; p[2] = 8'h3C; p[3] = 8'h81;
        do_reset();
        repeat (3) send_bit(1'b1, 0);
        send_frame(SA, 1'b1, 0);
        flush();
        // R4 first header byte alone is not lock
        chk(!locked, "R4 lock after SYNC_A only", locked, 0);
        send_frame(SB, 1'b1, 0);
        flush();
        // R5
        chk(locked, "R5 lock after SYNC_B", locked, 1);
        for (int i = 0; i < 4; i++) send_frame(p[i], 1'b1, 0);
        send_frame(p[0] ^ p[1] ^ p[2] ^ p[3], 1'b1, 0);
        flush();
        // R2 / R6 byte count and values
        chk(rx_n == PAY_LEN, "R6 payload byte count", rx_n, PAY_LEN);
        for (int i = 0; i < 4; i++)
            chk(rx_q[i] == p[i], "R2 payload value", rx_q[i], p[i]);
        // R8
        chk(good_n == 1 && bad_n == 0, "R8 good packet pulse", good_n, 1);
        chk(locked, "R8 lock held after packet", locked, 1);
    endtask

    task automatic t_offsets();
        for (int k = 0; k < 10; k++) begin
            do_reset();
            repeat (k) send_bit(1'b1, 0);
            send_pkt(SA, SB, 8'h5A, 8'h00, 8'hFF, 8'h96,
                     8'h5A ^ 8'h00 ^ 8'hFF ^ 8'h96, -1, 0, 0);
            flush();
            // R3
            chk(good_n == 1 && rx_n == 4 && rx_q[3] == 8'h96,
                "R3 lock at bit offset", good_n, 1);
        end
    endtask

    task automatic t_midstream();
        do_reset();
        send_pkt(SA, SB, 8'h47, 8'h50, 8'h53, 8'h0D, 8'h47 ^ 8'h50 ^ 8'h53 ^ 8'h0D, -1, 17, 0);
        send_pkt(SA, SB, 8'h24, 8'h31, 8'h32, 8'h33, 8'h24 ^ 8'h31 ^ 8'h32 ^ 8'h33, -1, 0, 0);
        send_pkt(SA, SB, 8'h61, 8'h62, 8'h63, 8'h64, 8'h61 ^ 8'h62 ^ 8'h63 ^ 8'h64, -1, 0, 0);
        flush();
        // R3 joining mid-packet: last packet must come through intact
        chk(good_n >= 1 && rx_n >= 4, "R3 mid-stream recovery", good_n, 1);
        chk(rx_n >= 4 && rx_q[rx_n-1] == 8'h64 && rx_q[rx_n-4] == 8'h61,
            "R3 mid-stream last payload", rx_n >= 4 ? rx_q[rx_n-1] : 0, 8'h64);
        chk(locked, "R3 locked after recovery", locked, 1);
    endtask

    task automatic t_false_header();
        do_reset();
        send_frame(SA, 1'b1, 0);
        send_frame(8'h77, 1'b1, 0);
        flush();
        // R4
        chk(!locked && rx_n == 0, "R4 SYNC_A then other value", locked, 0);
        send_pkt(SA, SB, 8'h01, 8'h02, 8'h04, 8'h08, 8'h0F, -1, 0, 0);
        flush();
        chk(good_n == 1 && rx_n == 4, "R4 lock on real header", good_n, 1);
    endtask

    task automatic t_bad_check();
        do_reset();
        send_pkt(SA, SB, 8'h10, 8'h20, 8'h30, 8'h40, 8'h41, -1, 0, 0);
        flush();
        // R9
        chk(bad_n == 1 && good_n == 0, "R9 bad check pulse", bad_n, 1);
        chk(locked, "R9 lock held after bad check", locked, 1);
        send_pkt(SA, SB, 8'hAA, 8'h55, 8'hF0, 8'h0F, 8'h00, -1, 0, 0);
        flush();
        chk(good_n == 1 && rx_n == 8, "R9 next packet good", good_n, 1);
    endtask

    task automatic t_broken_stop();
        do_reset();
        send_pkt(SA, SB, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12 ^ 8'h34 ^ 8'h56 ^ 8'h78, 3, 0, 0);
        flush();
        // R7
        chk(!locked, "R7 lock dropped on broken stop", locked, 0);
        chk(bad_n == 1 && good_n == 0, "R7 bad pulse on broken stop", bad_n, 1);
        chk(rx_n == 1, "R7 bytes before break", rx_n, 1);
    endtask

    task automatic t_bad_header_locked();
        do_reset();
        send_pkt(SA, SB, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0A ^ 8'h0B ^ 8'h0C ^ 8'h0D, -1, 0, 0);
        send_pkt(SA, 8'h00, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h00, -1, 0, 0);
        flush();
        // R10
        chk(!locked, "R10 lock dropped on bad header", locked, 0);
        chk(good_n == 1 && bad_n == 0 && rx_n == 4, "R10 no packet pulse", bad_n, 0);
    endtask

    task automatic t_gaps();
        do_reset();
        send_pkt(SA, SB, 8'hC3, 8'h3C, 8'h99, 8'h66, 8'hC3 ^ 8'h3C ^ 8'h99 ^ 8'h66, -1, 0, 2);
        flush();
        // R11
        chk(good_n == 1 && rx_n == 4, "R11 packet with idle gaps", good_n, 1);
        chk(rx_q[2] == 8'h99, "R11 payload with idle gaps", rx_q[2], 8'h99);
        repeat (20) @(negedge clk);
        chk(locked && good_n == 1 && bad_n == 0, "R11 idle holds state", locked, 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_offsets();
        t_midstream();
        t_false_header();
        t_bad_check();
        t_broken_stop();
        t_bad_header_locked();
        t_gaps();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule